// File: doc/BRIEF.md
# Per-Pin Input Glitch Filter with Shared Sample Divider

This block sits between the input synchronisers of a 32-pin general-purpose port and the interrupt edge and level detector. It removes short glitches from each input before they can raise an interrupt or wake the system. Each pin is configured on its own through two bits. Together they choose one of three treatments: pass the pin through untouched, filter it at the system clock rate, or filter it at a slower rate set by a sample tick.

All pins share one sample tick. It comes from a single divider programmed with a 24-bit value `d` and fires once every 2 × (d + 1) system clock cycles. A filtered pin takes on the value of its raw input only when two consecutive samples of that input agree and differ from the current filtered value. A pulse shorter than one sample interval therefore never reaches the output. Changing the divider value restarts the divider's count. When no pin uses the divided tick, the divider stays at rest.

Top module: `dbf_debounce_top`

## Requirements
- R1: When a pin's `filt_on` bit is 0, its `pin_clean` bit equals its `pin_sync` bit in the same cycle. While the bit is 0, the pin's filter state follows the input on every clock edge, so filtering starts from the present input level once the bit is set again.
- R2: When `divide_sel` is non-zero, the sample tick fires during one cycle in every 2 × (`div_value` + 1) cycles. A count that starts at 0 fires the tick in its (2 × `div_value` + 2)-th cycle and then returns to 0. Two ticks never fall in adjacent cycles.
- R3: For a pin with `filt_on` = 1 and `divide_sel` = 0, the input is sampled on every clock edge. The output takes a new input value on the second consecutive edge at which it sees that value, so a one-cycle pulse is rejected.
- R4: For a pin with `filt_on` = 1 and `divide_sel` = 1, the input is sampled only at edges where the tick is high. The output changes only at such an edge, and only when that sample equals the previous tick's sample and differs from the output.
- R5: A `div_value` that differs from the value of the previous cycle resets the divider count to 0. With the new value `d`, the next tick falls 2 × (d + 1) cycles after the change.
- R6: While every bit of `divide_sel` is 0, the divider count is held at 0 and no tick fires. After a bit is set, the first tick follows 2 × (`div_value` + 1) cycles later.
- R7: During reset (`rst_n` = 0, sampled synchronously) the filter state of every pin is loaded from `pin_sync`. The first outputs after reset therefore equal the inputs that were present at the last reset edge.
- R8: Pins in different modes work side by side with no interaction. The only state they share is the sample tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_sync | input | 32 | Synchronised raw pin levels |
| filt_on | input | 32 | Per-pin filter enable (0 = pass through) |
| divide_sel | input | 32 | Per-pin choice of the divided tick (1) or every system clock (0) |
| div_value | input | 24 | Shared divider value d; tick period 2 × (d + 1) cycles |
| pin_clean | output | 32 | Filtered pin levels |

## Verification
The assertions check on every cycle that pass-through pins mirror their inputs and that ticks never fall in adjacent cycles. They also check that no tick follows a cycle in which the divider was idle or its value changed. Finally, they check that a filtered pin only ever moves to a level its input held on the previous cycle, and that a divided pin only moves right after a tick. Only the bench scenarios can show the exact tick period for a given divider value, the rejection of pulses of specific lengths, restart timing after a value change, and pins in mixed modes running together. A behavioural model that compares every output bit on every clock covers these.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  typedef enum logic [1:0] {
    MODE_PASS    = 2'd0,
    MODE_FAST    = 2'd1,
    MODE_DIVIDED = 2'd2
  } pin_mode_e;

  function automatic pin_mode_e pick_mode(input logic filt, input logic div_sel);
    if (!filt)       return MODE_PASS;
    else if (div_sel) return MODE_DIVIDED;
    else             return MODE_FAST;
  endfunction

endpackage

// File: rtl/dbf_tick_gen.sv
module dbf_tick_gen #(
  parameter int DIV_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_value,
  output logic             tick,
  output logic             restart
);
  localparam int CNT_W = DIV_W + 1;

  // last count value of one period: 2*d + 1
  function automatic logic [CNT_W-1:0] last_count(input logic [DIV_W-1:0] d);
    return {d, 1'b1};
  endfunction

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;

  assign restart = (div_value != div_q);
  assign tick    = (cnt_q == last_count(div_value));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= div_value;
      cnt_q <= '0;
    end else begin
      div_q <= div_value;
      if (restart || !run || tick) cnt_q <= '0;
      else                         cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dbf_lane.sv
module dbf_lane
  import dbf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic filt_on,
  input  logic div_sel,
  input  logic tick,
  output logic clean,
  output logic take,
  output logic update
);
  pin_mode_e mode;
  logic smp_q, out_q, agree_new;

  assign mode      = pick_mode(filt_on, div_sel);
  assign take      = (mode == MODE_DIVIDED) ? tick : 1'b1;
  assign agree_new = (raw == smp_q) && (raw != out_q);
  assign update    = rst_n && (mode != MODE_PASS) && take && agree_new;
  assign clean     = (mode == MODE_PASS) ? raw : out_q;

  always_ff @(posedge clk) begin
    if (!rst_n || mode == MODE_PASS) begin
      smp_q <= raw;
      out_q <= raw;
    end else if (take) begin
      smp_q <= raw;
      if (agree_new) out_q <= raw;
    end
  end
endmodule

// File: rtl/dbf_debounce_top.sv
module dbf_debounce_top #(
  parameter int N_PINS = 32,
  parameter int DIV_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_sync,
  input  logic [N_PINS-1:0] filt_on,
  input  logic [N_PINS-1:0] divide_sel,
  input  logic [DIV_W-1:0]  div_value,
  output logic [N_PINS-1:0] pin_clean
);
  logic              sample_tick;
  logic              div_restart;
  logic              div_run;
  logic [N_PINS-1:0] lane_take;
  logic [N_PINS-1:0] lane_update;

  assign div_run = |divide_sel;

  dbf_tick_gen #(.DIV_W(DIV_W)) tick_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (div_run),
    .div_value (div_value),
    .tick      (sample_tick),
    .restart   (div_restart)
  );

  for (genvar g = 0; g < N_PINS; g++) begin : g_lane
    dbf_lane lane_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw     (pin_sync[g]),
      .filt_on (filt_on[g]),
      .div_sel (divide_sel[g]),
      .tick    (sample_tick),
      .clean   (pin_clean[g]),
      .take    (lane_take[g]),
      .update  (lane_update[g])
    );
  end
endmodule

// File: rtl/dbf_debounce_chk.sv
module dbf_debounce_chk #(
  parameter int N_PINS = 32,
  parameter int DIV_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_PINS-1:0] pin_sync,
  input logic [N_PINS-1:0] filt_on,
  input logic [N_PINS-1:0] divide_sel,
  input logic [DIV_W-1:0]  div_value,
  input logic [N_PINS-1:0] pin_clean,
  input logic              sample_tick
);
  logic live_q;
  always_ff @(posedge clk) live_q <= rst_n;

  always_comb begin
    if (rst_n) begin
      assert_bypass_R1: assert (((pin_clean ^ pin_sync) & ~filt_on) == '0);
    end
  end

  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && sample_tick |=> !sample_tick);

  assert_filtered_prev_R3: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (((pin_clean ^ $past(pin_clean)) & filt_on & $past(filt_on)
                 & ($past(pin_sync) ^ pin_clean)) == '0));

  assert_divided_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && (|((pin_clean ^ $past(pin_clean)) & filt_on & $past(filt_on)
                 & divide_sel & $past(divide_sel))) |-> $past(sample_tick));

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && !$stable(div_value) |=> !sample_tick);

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && (divide_sel == '0) |=> !sample_tick);
endmodule

bind dbf_debounce_top dbf_debounce_chk #(.N_PINS(N_PINS), .DIV_W(DIV_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .pin_sync    (pin_sync),
  .filt_on     (filt_on),
  .divide_sel  (divide_sel),
  .div_value   (div_value),
  .pin_clean   (pin_clean),
  .sample_tick (sample_tick)
);

// File: tb/dbf_debounce_top_tb_top.sv
`timescale 1ns/1ps
module dbf_debounce_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pin_sync, filt_on, divide_sel;
  logic [23:0] div_value;
  logic [31:0] pin_clean;

  int    total = 0, bad = 0;
  bit    done  = 0;
  string phase = "R7";

  always #2.5 clk = ~clk;

  dbf_debounce_top dut_i (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .filt_on(filt_on),
    .divide_sel(divide_sel), .div_value(div_value), .pin_clean(pin_clean)
  );

  // behavioural reference
  longint m_cnt;
  longint m_prev_div;
  bit     m_s[32];
  bit     m_o[32];

  always @(posedge clk) begin
    bit tk;
    tk = (m_cnt == 2 * longint'(div_value) + 1);
    for (int i = 0; i < 32; i++) begin
      if (!rst_n || !filt_on[i]) begin
        m_s[i] = pin_sync[i]; m_o[i] = pin_sync[i];
      end else if (!divide_sel[i] || tk) begin
        if (pin_sync[i] == m_s[i] && pin_sync[i] != m_o[i]) m_o[i] = pin_sync[i];
        m_s[i] = pin_sync[i];
      end
    end
    if (!rst_n || longint'(div_value) != m_prev_div || divide_sel == 0 || tk) m_cnt = 0;
    else m_cnt = m_cnt + 1;
    m_prev_div = longint'(div_value);
  end

  function automatic logic [31:0] model_out();
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = filt_on[i] ? m_o[i] : pin_sync[i];
    return r;
  endfunction

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check_eq(phase, pin_clean, model_out());
    end
  endtask

  logic [31:0] lfsr = 32'h1ACE_B00C;
  function automatic logic [31:0] nxt(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    m_cnt = 0; m_prev_div = 0;
    rst_n = 0; pin_sync = 32'hA5A5_0F0F; filt_on = '1; divide_sel = '0; div_value = 24'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R7: first output after reset equals input held at reset
    @(negedge clk);
    check_eq("R7", pin_clean, 32'hA5A5_0F0F);
    step(2);

    // R1: pass-through on upper half
    phase = "R1"; filt_on = 32'h0000_FFFF;
    for (int k = 0; k < 20; k++) begin
      lfsr = nxt(lfsr); pin_sync = lfsr;
      #0.1 check_eq("R1", pin_clean & 32'hFFFF_0000, lfsr & 32'hFFFF_0000);
      step(1);
    end

    // R3: fast filtering, glitch rejection then stable change
    phase = "R3"; filt_on = '1; pin_sync = 32'h1234_5678; step(4);
    held = pin_clean;
    pin_sync = ~32'h1234_5678; step(1);
    pin_sync = 32'h1234_5678; step(3);
    check_eq("R3", pin_clean, held);
    pin_sync = 32'h0F0F_F0F0; step(1);
    check_eq("R3", pin_clean, held);
    step(1);
    check_eq("R3", pin_clean, 32'h0F0F_F0F0);
    for (int k = 0; k < 60; k++) begin
      if (k % 3 == 0) begin lfsr = nxt(lfsr); pin_sync = lfsr; end
      step(1);
    end

    // R2/R4: divided filtering with d=3 (period 8)
    phase = "R4"; div_value = 24'd3; divide_sel = '1;
    for (int k = 0; k < 300; k++) begin
      if (k % 11 == 0) begin lfsr = nxt(lfsr); pin_sync = lfsr; end
      else if (k % 11 == 5) pin_sync = pin_sync ^ 32'h0000_00FF;
      else if (k % 11 == 6) pin_sync = pin_sync ^ 32'h0000_00FF;
      step(1);
    end
    phase = "R2"; div_value = 24'd0;
    for (int k = 0; k < 80; k++) begin
      if (k % 5 == 0) begin lfsr = nxt(lfsr); pin_sync = lfsr; end
      step(1);
    end

    // R5: value changes in the middle of a count
    phase = "R5"; div_value = 24'd6; step(9);
    div_value = 24'd2;
    for (int k = 0; k < 60; k++) begin
      if (k % 4 == 1) begin lfsr = nxt(lfsr); pin_sync = lfsr; end
      if (k == 20) div_value = 24'd5;
      step(1);
    end

    // R6: idle divider, then re-enable
    phase = "R6"; divide_sel = '0; div_value = 24'd4; step(12);
    divide_sel = 32'h0000_0001; pin_sync = ~pin_sync;
    for (int k = 0; k < 50; k++) begin
      if (k % 13 == 0) begin lfsr = nxt(lfsr); pin_sync = lfsr; end
      step(1);
    end

    // R8: mixed modes side by side
    phase = "R8"; filt_on = 32'hF0F0_F0F0; divide_sel = 32'hFF00_FF00; div_value = 24'd1;
    for (int k = 0; k < 400; k++) begin
      if (k % 3 == 0) begin lfsr = nxt(lfsr); pin_sync = lfsr; end
      else pin_sync = pin_sync ^ (lfsr & 32'h0303_0303);
      step(1);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule